// File: doc/BRIEF.md
# Dual-Bank Word Selector with Held Bit

This block sits behind two stored configuration words and chooses which one drives the device outputs. The low five bits of the chosen word go straight to a 5-bit output. A sixth bit of the chosen word goes to a separate single-bit output through a level-controlled hold stage.

The word is chosen by one of three sources. An override is active when the second word is entirely zero and the second select pin is high. A bank choice from the serial command logic applies when it is flagged valid. Otherwise the first select pin decides. The first select pin also gates the hold stage. While that pin is low, the stage follows the chosen word's bit on every clock. While it is high, the stage keeps its last value.

The hold stage is a clocked register with a load enable, so the block stays in one clock domain. The serial protocol and the storage of the words belong to neighbouring blocks.

Top module: `dbs_selector`

## Requirements
- R1: `mux_out` equals bits 4..0 of the selected word in the same cycle, with no register in the path.
- R2: When no override is active and `cmd_bank_vld` is 0, `sel_pin0` = 0 selects `word0` and `sel_pin0` = 1 selects `word1`.
- R3: When no override is active and `cmd_bank_vld` is 1, `cmd_bank` = 0 selects `word0` and `cmd_bank` = 1 selects `word1`, whatever `sel_pin0` is.
- R4: When `word1` is all zeros and `sel_pin1` is 1, `word0` is selected, whatever the command and `sel_pin0` are.
- R5: `sel_pin1` has no effect on the selection while `word1` is non-zero.
- R6: At each rising clock edge where `sel_pin0` is 0, `held_bit` loads bit 5 of the selected word. The new value is visible after that edge.
- R7: At each rising clock edge where `sel_pin0` is 1, `held_bit` keeps its value, even when the words or the selection change.
- R8: While `rst_n` is low, `held_bit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word0 | input | 8 | First stored word |
| word1 | input | 8 | Second stored word |
| sel_pin0 | input | 1 | Bank select pin; also the hold enable (1 = hold) |
| sel_pin1 | input | 1 | Override pin, active only while word1 is zero |
| cmd_bank_vld | input | 1 | Command bank choice is valid |
| cmd_bank | input | 1 | Command bank choice (0 = word0, 1 = word1) |
| mux_out | output | 5 | Low five bits of the selected word |
| held_bit | output | 1 | Held copy of bit 5 of the selected word |

## Verification
A wrong selection shows at `mux_out` in the same cycle, because the output path has no register. The stimulus therefore uses two words whose low fields differ, so that every wrong bank choice is visible. A fault in the hold stage shows one edge later on `held_bit`. The first kind is a missed load while `sel_pin0` is low. The second kind is a load while `sel_pin0` is high, which the stimulus exposes by changing the words during hold windows. The override is exercised with the command and the pins pointing the other way, so that a wrong priority order changes the output.

// File: rtl/dbs_pkg.sv
// Package: shared types for the dual-bank selector.
// Assumes the two words have the same width.
package dbs_pkg;
    typedef enum logic {
        BANK_LO = 1'b0,
        BANK_HI = 1'b1
    } bank_e;
endpackage

// File: rtl/dbs_bank_select.sv
// Module: dbs_bank_select
// Decides which word drives the outputs. The override has the highest
// priority, then a valid command, then the first select pin.
// Assumes all inputs are stable within the cycle.
module dbs_bank_select #(
    parameter int WORD_W = 8
) (
    input  logic [WORD_W-1:0] word1,
    input  logic              sel_pin0,
    input  logic              sel_pin1,
    input  logic              cmd_bank_vld,
    input  logic              cmd_bank,
    output dbs_pkg::bank_e    bank_sel
);
    import dbs_pkg::*;

    logic override;

    // Override qualifier: the pin counts only while the second word is empty.
    always_comb override = sel_pin1 && (word1 == '0);

    // Priority decode of the bank choice.
    always_comb begin
        if (override)          bank_sel = BANK_LO;
        else if (cmd_bank_vld) bank_sel = bank_e'(cmd_bank);
        else                   bank_sel = bank_e'(sel_pin0);
    end
endmodule

// File: rtl/dbs_word_mux.sv
// Module: dbs_word_mux
// Routes the low field and the held-bit source of the chosen word.
// Assumes MUX_W + 1 <= WORD_W and HOLD_IDX < WORD_W.
module dbs_word_mux #(
    parameter int WORD_W   = 8,
    parameter int MUX_W    = 5,
    parameter int HOLD_IDX = 5
) (
    input  logic [WORD_W-1:0] word0,
    input  logic [WORD_W-1:0] word1,
    input  dbs_pkg::bank_e    bank_sel,
    output logic [MUX_W-1:0]  field_out,
    output logic              hold_src
);
    import dbs_pkg::*;

    logic pick_hi;

    // Bank decode into a single steering bit.
    always_comb pick_hi = (bank_sel == BANK_HI);

    // One two-way selector per routed bit.
    for (genvar i = 0; i < MUX_W; i++) begin : g_bit
        always_comb field_out[i] = pick_hi ? word1[i] : word0[i];
    end

    // Source bit for the hold stage.
    always_comb hold_src = pick_hi ? word1[HOLD_IDX] : word0[HOLD_IDX];
endmodule

// File: rtl/dbs_bit_hold.sv
// Module: dbs_bit_hold
// A level hold stage built as a clocked register. It loads while hold_n
// is low and keeps its value while hold_n is high.
// Assumes a synchronous active-low reset that clears it to 0.
module dbs_bit_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_n,
    input  logic d,
    output logic q
);
    // Load or keep the held bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= 1'b0;
        else if (!hold_n) q <= d;
    end
endmodule

// File: rtl/dbs_selector.sv
// Module: dbs_selector (top)
// Drives a multiplexed field and a held bit from two stored words.
// Assumes the words come from storage that is stable between updates.
module dbs_selector #(
    parameter int WORD_W   = 8,
    parameter int MUX_W    = 5,
    parameter int HOLD_IDX = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word0,
    input  logic [WORD_W-1:0] word1,
    input  logic              sel_pin0,
    input  logic              sel_pin1,
    input  logic              cmd_bank_vld,
    input  logic              cmd_bank,
    output logic [MUX_W-1:0]  mux_out,
    output logic              held_bit
);
    import dbs_pkg::*;

    bank_e bank_sel;
    logic  hold_src;

    dbs_bank_select #(.WORD_W(WORD_W)) u_sel (
        .word1        (word1),
        .sel_pin0     (sel_pin0),
        .sel_pin1     (sel_pin1),
        .cmd_bank_vld (cmd_bank_vld),
        .cmd_bank     (cmd_bank),
        .bank_sel     (bank_sel)
    );

    dbs_word_mux #(.WORD_W(WORD_W), .MUX_W(MUX_W), .HOLD_IDX(HOLD_IDX)) u_mux (
        .word0     (word0),
        .word1     (word1),
        .bank_sel  (bank_sel),
        .field_out (mux_out),
        .hold_src  (hold_src)
    );

    dbs_bit_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_n (sel_pin0),
        .d      (hold_src),
        .q      (held_bit)
    );
endmodule

// File: rtl/dbs_selector_chk.sv
// Module: dbs_selector_chk
// Checker bound to dbs_selector. It relates the ports over time.
module dbs_selector_chk #(
    parameter int WORD_W   = 8,
    parameter int MUX_W    = 5,
    parameter int HOLD_IDX = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] word0,
    input logic [WORD_W-1:0] word1,
    input logic              sel_pin0,
    input logic              sel_pin1,
    input logic              cmd_bank_vld,
    input logic              cmd_bank,
    input logic [MUX_W-1:0]  mux_out,
    input logic              held_bit
);
    logic ovr;
    always_comb ovr = sel_pin1 && (word1 == '0);

    a_r4_override_low: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> mux_out == word0[MUX_W-1:0]);

    a_r3_cmd_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr && cmd_bank_vld) |->
            mux_out == (cmd_bank ? word1[MUX_W-1:0] : word0[MUX_W-1:0]));

    a_r2_pin_pick: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr && !cmd_bank_vld) |->
            mux_out == (sel_pin0 ? word1[MUX_W-1:0] : word0[MUX_W-1:0]));

    a_r7_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        sel_pin0 |=> $stable(held_bit));

    a_r6_load_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_pin0 && ovr) |=> held_bit == $past(word0[HOLD_IDX]));
endmodule

bind dbs_selector dbs_selector_chk #(
    .WORD_W(WORD_W), .MUX_W(MUX_W), .HOLD_IDX(HOLD_IDX)
) u_chk (.*);

// File: tb/dbs_selector_tb.sv
module dbs_selector_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] word0 = '0, word1 = '0;
    logic       sel_pin0 = 1'b0, sel_pin1 = 1'b0, cmd_bank_vld = 1'b0, cmd_bank = 1'b0;
    logic [4:0] mux_out;
    logic       held_bit;

    typedef struct {
        logic [4:0] mux;
        logic       held;
        string      tag;
    } item_t;

    item_t exp_q[$];
    int    n_cmp = 0, n_bad = 0;
    logic  model_held = 1'b0;
    bit    driving_done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    dbs_selector u_dut (.*);

    // Driver: set the inputs at a falling edge and queue the expected result.
    task automatic drive(input logic [7:0] w0, input logic [7:0] w1,
                         input logic p0, input logic p1,
                         input logic v, input logic c, input string tag);
        logic [7:0] sel;
        @(negedge clk);
        word0 = w0; word1 = w1; sel_pin0 = p0; sel_pin1 = p1;
        cmd_bank_vld = v; cmd_bank = c;
        if (p1 && w1 == 8'h00) sel = w0;        // R4
        else if (v)            sel = c ? w1 : w0;  // R3
        else                   sel = p0 ? w1 : w0; // R2, R5
        if (!p0) model_held = sel[5];           // R6, R7
        exp_q.push_back('{mux: sel[4:0], held: model_held, tag: tag});
    endtask

    // Monitor: sample just after the rising edge and compare.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                n_cmp++;
                if (mux_out !== it.mux || held_bit !== it.held) begin
                    n_bad++;
                    $display("FAIL %s: mux_out=%h held_bit=%b expected mux_out=%h held_bit=%b",
                             it.tag, mux_out, held_bit, it.mux, it.held);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R8: reset clears the held bit even with a 1 on the load path.
        word0 = 8'h20;
        repeat (3) @(posedge clk);
        #1;
        n_cmp++;
        if (held_bit !== 1'b0) begin
            n_bad++;
            $display("FAIL R8: held_bit=%b expected 0", held_bit);
        end
        @(negedge clk);
        rst_n = 1'b1;

        drive(8'h2A, 8'h15, 0, 0, 0, 0, "R2_R6 pin0 low picks word0");
        drive(8'h2A, 8'h15, 1, 0, 0, 0, "R2_R7 pin0 high picks word1, hold");
        drive(8'h2A, 8'h15, 1, 0, 1, 0, "R3 cmd picks word0 over pin");
        drive(8'h2A, 8'hC3, 0, 0, 1, 1, "R3_R6 cmd picks word1, load");
        drive(8'h37, 8'h00, 1, 1, 1, 1, "R4 override beats cmd and pin");
        drive(8'h37, 8'h00, 0, 1, 0, 0, "R4_R6 override load from word0");
        drive(8'h37, 8'h00, 1, 0, 0, 0, "R2 empty word1 without override");
        drive(8'h37, 8'h09, 1, 1, 0, 0, "R5 pin1 ignored, word1 nonzero");
        drive(8'h1F, 8'h2E, 0, 1, 0, 0, "R5 pin1 ignored during load");
        drive(8'hDF, 8'h3C, 1, 0, 0, 0, "R7 hold across word change");
        drive(8'h20, 8'hE1, 1, 0, 1, 0, "R7 hold across cmd change");
        drive(8'h20, 8'hE1, 0, 0, 0, 0, "R6 reload after hold");
        drive(8'h00, 8'h1F, 0, 0, 1, 1, "R1_R6 full field from word1");
        for (int k = 0; k < 16; k++) begin
            drive(8'(k * 29 + 3), 8'(k * 53 + 1), k[0], k[1], k[2], k[3],
                  "R1 sweep of selectors");
        end
        repeat (3) @(posedge clk);
        #2;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule